// File: doc/BRIEF.md
# Auto-Incrementing Packet Data Window

This block gives a host a narrow window onto a packet buffer RAM. The buffer is split into fixed-size packets, each a whole number of 256-byte pages. The host chooses a packet either by loading a packet-number register or by setting a receive-select flag, which makes the window follow whichever packet number sits at the head of a small receive queue. A pointer register holds a byte offset into the selected packet and three mode flags: read direction, receive-select and auto-advance. Host traffic then goes through one data port that takes 16-bit word or 8-bit byte accesses. With auto-advance on, each access moves the offset on by its own width, so a whole frame can be streamed with a single pointer write. A frame of odd length ends with one byte access.

The data port is a valid/ready stream. The host offers an access with `acc_valid`, and it is taken on a clock edge where `acc_ready` is high. A read returns its data one cycle later on a valid/ready response channel. That channel holds a single entry. While a response is waiting and `rsp_ready` is low, no new access is taken, and `rsp_valid` and `rsp_data` stay frozen. The receive queue fills from the network side through a valid/ready push port, and the host drops its head with a release pulse. On a transmit failure, the network side presents a status word, which is written over the first word of the failed packet so that the host can read it back from offset 0.

Packet layout is a convention used by software and is not enforced by the block: a status word at offset 0, a byte count at offset 2 that includes the 6 overhead bytes, the frame, then a control byte and a spare byte.

Top module: `pdw_window`

## Requirements
- R1: After reset the offset is 0, all three mode flags are clear (write direction, register-selected packet, no auto-advance), the packet-number register is 0, the receive queue is empty (`rx_empty`=1, `rxq_ready`=1) and no response is pending (`rsp_valid`=0).
- R2: A pointer write (`ptr_wr`) loads the offset and the flags `ptr_rd`, `ptr_rcv`, `ptr_inc`. In a cycle with a pointer write, `acc_ready` is 0, so the pointer write wins over a data access.
- R3: With the read flag set, an accepted access is a read. With the flag clear, the access writes `acc_wdata` and produces no response.
- R4: A word access at offset o covers the byte at o (bits 7:0) and the byte at o+1 (bits 15:8), little-endian. The o+1 address wraps to 0 inside the same packet.
- R5: A byte access (`acc_byte`=1) writes `acc_wdata[7:0]` at the offset. A byte read returns the byte in bits 7:0, with bits 15:8 equal to zero.
- R6: With auto-advance set, each accepted access adds 2 (word) or 1 (byte) to the offset, modulo the packet size. With auto-advance clear, the offset does not move.
- R7: The RAM byte address is packet × PAGES_PER_PKT × 256 + offset, so the same offset in different packets refers to separate storage.
- R8: With the receive-select flag set, the packet is the receive-queue head and the packet-number register has no effect. If the queue is empty, `acc_ready` stays 0.
- R9: The receive queue is FIFO with RXQ_DEPTH entries. `rxq_ready` is 0 when the queue is full and a push offered then is dropped. `rx_release` removes the head and has no effect when the queue is empty.
- R10: A read response appears in the cycle after the read is accepted. It holds `rsp_valid` and a stable `rsp_data` until `rsp_ready`, and `acc_ready` is 0 while it is held.
- R11: `txf_valid` writes `txf_status` as the word at offset 0 of packet `txf_pnum`. In that cycle it has priority and `acc_ready` is 0.
- R12: A packet-number write (`pnum_wr`) selects the packet used by accesses accepted in later cycles when receive-select is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pnum_wr | input | 1 | Load packet-number register |
| pnum_wdata | input | PN_W | Packet number to load |
| ptr_wr | input | 1 | Load pointer register |
| ptr_off | input | OFF_W | Byte offset to load |
| ptr_rd | input | 1 | Read-direction flag |
| ptr_rcv | input | 1 | Receive-select flag |
| ptr_inc | input | 1 | Auto-advance flag |
| acc_valid | input | 1 | Data access offered |
| acc_ready | output | 1 | Data access taken this edge |
| acc_byte | input | 1 | 1 = byte access, 0 = word access |
| acc_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Host takes read data |
| rsp_data | output | 16 | Read data |
| rxq_valid | input | 1 | Receive packet number offered |
| rxq_ready | output | 1 | Receive queue has room |
| rxq_pnum | input | PN_W | Receive packet number |
| rx_release | input | 1 | Drop receive-queue head |
| rx_empty | output | 1 | Receive queue empty |
| txf_valid | input | 1 | Transmit-failure status write |
| txf_pnum | input | PN_W | Failed packet number |
| txf_status | input | 16 | Status word to store |

## Verification
The bench fills every packet of a small configuration using auto-advancing word writes, then reads each one back and compares against a value computed from packet and offset. A mistake in the packet base arithmetic or the byte order therefore shows up as corrupted data in neighbouring packets or as swapped bytes. Targeted cases cover the following: a word at the last offset of a packet, which must wrap inside that packet rather than spill into the next one; byte steps mixed with word steps; accesses with auto-advance off, which must not move the offset; pointer writes and status writes that collide with an access, where a design with the wrong priority would take the access; receive-select on an empty or full queue, where a design would read a stale packet or accept an extra entry; and a response held by back-pressure, where a faulty design would lose or overwrite the read data.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

  typedef struct packed {
    logic rd;
    logic rcv;
    logic inc;
  } ptr_mode_t;

  localparam int unsigned PAGE_BYTES = 256;

endpackage

// File: rtl/pdw_rxq.sv
module pdw_rxq #(
  parameter int unsigned PN_W  = 2,
  parameter int unsigned DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_valid,
  output logic            push_ready,
  input  logic [PN_W-1:0] push_pnum,
  input  logic            pop,
  output logic [PN_W-1:0] head,
  output logic            empty
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [PN_W-1:0]  slot [DEPTH];
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [CNT_W-1:0] cnt;
  logic             push_ok, pop_ok;

  assign push_ready = (cnt != CNT_W'(DEPTH));
  assign empty      = (cnt == '0);
  assign push_ok    = push_valid && push_ready;
  assign pop_ok     = pop && !empty;
  assign head       = slot[rd_idx];

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + IDX_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) slot[wr_idx] <= push_pnum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_idx <= nxt(wr_idx);
      if (pop_ok)  rd_idx <= nxt(rd_idx);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R9: occupancy never exceeds the depth
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  // R9: a release on an empty queue leaves it empty when nothing is pushed
  a_r9_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push_valid) |=> empty);

  // R9: a push offered to a full queue without a pop leaves it full
  a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ready && push_valid && !pop) |=> !push_ready);

endmodule

// File: rtl/pdw_ptr.sv
module pdw_ptr
  import pdw_pkg::*;
#(
  parameter int unsigned OFF_W = 9,
  parameter int unsigned PN_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_wr,
  input  logic [OFF_W-1:0] ptr_off,
  input  ptr_mode_t        mode_in,
  input  logic             pnum_wr,
  input  logic [PN_W-1:0]  pnum_wdata,
  input  logic             adv,
  input  logic             adv_byte,
  output logic [OFF_W-1:0] off,
  output ptr_mode_t        mode,
  output logic [PN_W-1:0]  pnum
);
  logic [OFF_W-1:0] step;
  assign step = adv_byte ? OFF_W'(1) : OFF_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off  <= '0;
      mode <= '0;
      pnum <= '0;
    end else begin
      if (ptr_wr) begin
        off  <= ptr_off;
        mode <= mode_in;
      end else if (adv && mode.inc) begin
        off <= off + step;
      end
      if (pnum_wr) pnum <= pnum_wdata;
    end
  end

  // R6: without an advancing access or pointer write the offset holds
  a_r6_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && !(adv && mode.inc)) |=> $stable(off));

  // R6: an advancing access moves the offset by its width
  a_r6_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && adv && mode.inc) |=>
      off == $past(off) + ($past(adv_byte) ? OFF_W'(1) : OFF_W'(2)));

  // R2: a pointer write loads the offset
  a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> off == $past(ptr_off));

endmodule

// File: rtl/pdw_ram.sv
module pdw_ram #(
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [AW-1:0] wa_lo,
  input  logic [AW-1:0] wa_hi,
  input  logic [7:0]    wd_lo,
  input  logic [7:0]    wd_hi,
  input  logic [AW-1:0] ra_lo,
  input  logic [AW-1:0] ra_hi,
  output logic [7:0]    q_lo,
  output logic [7:0]    q_hi
);
  localparam int unsigned BYTES = 1 << AW;

  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (we_lo) mem[wa_lo] <= wd_lo;
    if (we_hi) mem[wa_hi] <= wd_hi;
  end

  assign q_lo = mem[ra_lo];
  assign q_hi = mem[ra_hi];

  // R4: the two bytes of a word write never land on the same address
  a_r4_lanes_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lo && we_hi) |-> (wa_lo != wa_hi));

endmodule

// File: rtl/pdw_window.sv
module pdw_window
  import pdw_pkg::*;
#(
  parameter int unsigned N_PKT         = 4,
  parameter int unsigned PAGES_PER_PKT = 2,
  parameter int unsigned RXQ_DEPTH     = 4,
  localparam int unsigned PN_W      = (N_PKT > 1) ? $clog2(N_PKT) : 1,
  localparam int unsigned PKT_BYTES = PAGES_PER_PKT * PAGE_BYTES,
  localparam int unsigned OFF_W     = $clog2(PKT_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pnum_wr,
  input  logic [PN_W-1:0]  pnum_wdata,
  input  logic             ptr_wr,
  input  logic [OFF_W-1:0] ptr_off,
  input  logic             ptr_rd,
  input  logic             ptr_rcv,
  input  logic             ptr_inc,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic             acc_byte,
  input  logic [15:0]      acc_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [15:0]      rsp_data,
  input  logic             rxq_valid,
  output logic             rxq_ready,
  input  logic [PN_W-1:0]  rxq_pnum,
  input  logic             rx_release,
  output logic             rx_empty,
  input  logic             txf_valid,
  input  logic [PN_W-1:0]  txf_pnum,
  input  logic [15:0]      txf_status
);
  // packet size is a power of two, so base*size+offset is a concatenation
  localparam int unsigned AW = PN_W + OFF_W;

  ptr_mode_t        mode;
  ptr_mode_t        mode_in;
  logic [OFF_W-1:0] off, off_hi;
  logic [PN_W-1:0]  pnum, rx_head, pkt_sel;
  logic             stall_rcv, rsp_free, acc_fire;
  logic             we_lo, we_hi;
  logic [AW-1:0]    wa_lo, wa_hi, ra_lo, ra_hi;
  logic [7:0]       wd_lo, wd_hi, q_lo, q_hi;

  assign mode_in = '{rd: ptr_rd, rcv: ptr_rcv, inc: ptr_inc};

  pdw_ptr #(.OFF_W(OFF_W), .PN_W(PN_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_wr     (ptr_wr),
    .ptr_off    (ptr_off),
    .mode_in    (mode_in),
    .pnum_wr    (pnum_wr),
    .pnum_wdata (pnum_wdata),
    .adv        (acc_fire),
    .adv_byte   (acc_byte),
    .off        (off),
    .mode       (mode),
    .pnum       (pnum)
  );

  pdw_rxq #(.PN_W(PN_W), .DEPTH(RXQ_DEPTH)) u_rxq (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (rxq_valid),
    .push_ready (rxq_ready),
    .push_pnum  (rxq_pnum),
    .pop        (rx_release),
    .head       (rx_head),
    .empty      (rx_empty)
  );

  // access arbitration: status write, then pointer write, then host data
  assign pkt_sel   = mode.rcv ? rx_head : pnum;
  assign stall_rcv = mode.rcv && rx_empty;
  assign rsp_free  = !rsp_valid || rsp_ready;
  assign acc_ready = !txf_valid && !ptr_wr && !stall_rcv && rsp_free;
  assign acc_fire  = acc_valid && acc_ready;
  assign off_hi    = off + OFF_W'(1);

  assign ra_lo = {pkt_sel, off};
  assign ra_hi = {pkt_sel, off_hi};

  always_comb begin
    we_lo = 1'b0;
    we_hi = 1'b0;
    wa_lo = ra_lo;
    wa_hi = ra_hi;
    wd_lo = acc_wdata[7:0];
    wd_hi = acc_wdata[15:8];
    if (txf_valid) begin
      we_lo = 1'b1;
      we_hi = 1'b1;
      wa_lo = {txf_pnum, OFF_W'(0)};
      wa_hi = {txf_pnum, OFF_W'(1)};
      wd_lo = txf_status[7:0];
      wd_hi = txf_status[15:8];
    end else if (acc_fire && !mode.rd) begin
      we_lo = 1'b1;
      we_hi = !acc_byte;
    end
  end

  pdw_ram #(.AW(AW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we_lo (we_lo),
    .we_hi (we_hi),
    .wa_lo (wa_lo),
    .wa_hi (wa_hi),
    .wd_lo (wd_lo),
    .wd_hi (wd_hi),
    .ra_lo (ra_lo),
    .ra_hi (ra_hi),
    .q_lo  (q_lo),
    .q_hi  (q_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (acc_fire && mode.rd) begin
      rsp_valid <= 1'b1;
      rsp_data  <= acc_byte ? {8'h00, q_lo} : {q_hi, q_lo};
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10: a held response keeps its data
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R10: an accepted read yields a response next cycle
  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && mode.rd) |=> rsp_valid);

  // R3: a write access with the channel drained produces no response
  a_r3_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && !mode.rd && (!rsp_valid || rsp_ready)) |=> !rsp_valid);

  // R8: receive-select on an empty queue never takes an access
  a_r8_rcv_empty_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.rcv && rx_empty) |-> !(acc_valid && acc_ready));

  // R11: a status write and a host write never share the write port
  a_r11_txf_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    txf_valid |-> !(acc_valid && acc_ready));

endmodule

// File: tb/tb_pdw_window.sv
module tb_pdw_window;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 4;
  localparam int PPP = 1;
  localparam int DEP = 4;
  localparam int PN  = 2;
  localparam int OW  = 8;

  logic clk = 0, rst_n = 0;
  logic pnum_wr = 0; logic [PN-1:0] pnum_wdata = 0;
  logic ptr_wr = 0; logic [OW-1:0] ptr_off = 0;
  logic ptr_rd = 0, ptr_rcv = 0, ptr_inc = 0;
  logic acc_valid = 0, acc_ready, acc_byte = 0;
  logic [15:0] acc_wdata = 0;
  logic rsp_valid, rsp_ready = 1;
  logic [15:0] rsp_data;
  logic rxq_valid = 0, rxq_ready; logic [PN-1:0] rxq_pnum = 0;
  logic rx_release = 0, rx_empty;
  logic txf_valid = 0; logic [PN-1:0] txf_pnum = 0; logic [15:0] txf_status = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdw_window #(.N_PKT(NP), .PAGES_PER_PKT(PPP), .RXQ_DEPTH(DEP)) dut (
    .clk(clk), .rst_n(rst_n), .pnum_wr(pnum_wr), .pnum_wdata(pnum_wdata),
    .ptr_wr(ptr_wr), .ptr_off(ptr_off), .ptr_rd(ptr_rd), .ptr_rcv(ptr_rcv),
    .ptr_inc(ptr_inc), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_byte(acc_byte), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rxq_valid(rxq_valid),
    .rxq_ready(rxq_ready), .rxq_pnum(rxq_pnum), .rx_release(rx_release),
    .rx_empty(rx_empty), .txf_valid(txf_valid), .txf_pnum(txf_pnum),
    .txf_status(txf_status));

  function automatic logic [7:0] pat(input int p, input int o);
    return 8'((p * 37 + (o % 256) * 5 + 3) & 255);
  endfunction

  function automatic logic [15:0] wpat(input int p, input int o);
    return {pat(p, (o + 1) % 256), pat(p, o)};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_pnum(input int p);
    @(negedge clk); pnum_wr = 1; pnum_wdata = PN'(p);
    @(negedge clk); pnum_wr = 0;
  endtask

  task automatic set_ptr(input int o, input logic rd, input logic rcv, input logic inc);
    @(negedge clk); ptr_wr = 1; ptr_off = OW'(o); ptr_rd = rd; ptr_rcv = rcv; ptr_inc = inc;
    @(negedge clk); ptr_wr = 0;
  endtask

  task automatic do_wr(input logic b, input logic [15:0] d);
    @(negedge clk); acc_valid = 1; acc_byte = b; acc_wdata = d;
    #1; while (!acc_ready) begin @(negedge clk); #1; end
    @(negedge clk); acc_valid = 0;
  endtask

  task automatic do_rd(input logic b, output logic [15:0] d);
    @(negedge clk); acc_valid = 1; acc_byte = b;
    #1; while (!acc_ready) begin @(negedge clk); #1; end
    @(negedge clk); acc_valid = 0; d = rsp_valid ? rsp_data : 16'hxxxx;
  endtask

  task automatic push_rx(input int p);
    @(negedge clk); rxq_valid = 1; rxq_pnum = PN'(p);
    @(negedge clk); rxq_valid = 0;
  endtask

  task automatic release_rx();
    @(negedge clk); rx_release = 1;
    @(negedge clk); rx_release = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state at the ports
    chk("R1 rsp_valid", {15'd0, rsp_valid}, 16'd0);
    chk("R1 rx_empty", {15'd0, rx_empty}, 16'd1);
    chk("R1 rxq_ready", {15'd0, rxq_ready}, 16'd1);
    chk("R1 acc_ready", {15'd0, acc_ready}, 16'd1);
    // R1: default flags write at offset 0 of packet 0, no advance
    do_wr(1, 16'h0077);
    chk("R3 write gives no response", {15'd0, rsp_valid}, 16'd0);
    do_wr(1, 16'h0066);
    set_ptr(0, 1, 0, 0);
    do_rd(1, d); chk("R1 reset offset/flags", d, 16'h0066);

    // fill every packet with word writes, auto-advance
    for (int p = 0; p < NP; p++) begin
      set_pnum(p);
      set_ptr(0, 0, 0, 1);
      for (int w = 0; w < 128; w++) do_wr(0, wpat(p, 2 * w));
    end
    // R4 R6 R7 R12 sweep readback
    for (int p = 0; p < NP; p++) begin
      set_pnum(p);
      set_ptr(0, 1, 0, 1);
      for (int w = 0; w < 128; w++) begin
        do_rd(0, d); chk("R7 R12 R4 word sweep", d, wpat(p, 2 * w));
      end
    end
    // R5 byte reads with byte step from an odd offset
    set_pnum(2); set_ptr(3, 1, 0, 1);
    for (int i = 0; i < 10; i++) begin
      do_rd(1, d); chk("R5 byte read", d, {8'h00, pat(2, 3 + i)});
    end
    // R6 mixed byte then word step
    set_pnum(1); set_ptr(5, 1, 0, 1);
    do_rd(1, d); chk("R6 mixed byte", d, {8'h00, pat(1, 5)});
    do_rd(0, d); chk("R6 mixed word", d, wpat(1, 6));
    // R4 wrap inside packet 3
    set_pnum(3); set_ptr(255, 0, 0, 1);
    do_wr(0, 16'hBEEF);
    do_wr(0, 16'h1234);
    set_ptr(255, 1, 0, 1);
    do_rd(0, d); chk("R4 wrap word", d, 16'hBEEF);
    do_rd(0, d); chk("R6 wrap advance", d, 16'h1234);
    set_pnum(0); set_ptr(0, 1, 0, 1);
    do_rd(0, d); chk("R7 neighbour untouched by wrap", d, wpat(0, 0));
    // R6 no advance
    set_ptr(20, 1, 0, 0);
    do_rd(0, d); chk("R6 hold read 1", d, wpat(0, 20));
    do_rd(0, d); chk("R6 hold read 2", d, wpat(0, 20));
    set_ptr(40, 0, 0, 0);
    do_wr(1, 16'h0011); do_wr(1, 16'h0022);
    set_ptr(40, 1, 0, 1);
    do_rd(1, d); chk("R6 hold write", d, 16'h0022);
    do_rd(1, d); chk("R5 neighbour byte", d, {8'h00, pat(0, 41)});
    // R2 pointer write beats access
    @(negedge clk); ptr_wr = 1; ptr_off = 8'd60; ptr_rd = 1; ptr_rcv = 0; ptr_inc = 1;
    acc_valid = 1; acc_byte = 0; #1;
    chk("R2 ptr priority", {15'd0, acc_ready}, 16'd0);
    @(negedge clk); ptr_wr = 0; acc_valid = 0;
    do_rd(0, d); chk("R2 ptr loaded", d, wpat(0, 60));
    // R8 receive select
    push_rx(2); push_rx(1);
    set_pnum(0);
    set_ptr(0, 1, 1, 1);
    do_rd(0, d); chk("R8 head pkt2", d, wpat(2, 0));
    release_rx();
    set_ptr(0, 1, 1, 1);
    do_rd(0, d); chk("R8 head pkt1", d, wpat(1, 0));
    release_rx();
    @(negedge clk); acc_valid = 1; acc_byte = 0; #1;
    chk("R8 empty stall", {15'd0, acc_ready}, 16'd0);
    chk("R9 empty flag", {15'd0, rx_empty}, 16'd1);
    @(negedge clk); acc_valid = 0;
    release_rx();
    push_rx(3);
    set_ptr(8, 1, 1, 1);
    do_rd(0, d); chk("R9 release on empty ignored", d, wpat(3, 8));
    release_rx();
    // R9 full queue
    for (int i = 0; i < DEP; i++) push_rx(i);
    @(negedge clk); #1;
    chk("R9 full ready low", {15'd0, rxq_ready}, 16'd0);
    push_rx(2);
    for (int i = 0; i < DEP; i++) begin
      set_ptr(16, 1, 1, 1);
      do_rd(0, d); chk("R9 fifo order", d, wpat(i, 16));
      release_rx();
    end
    @(negedge clk); #1;
    chk("R9 drop when full", {15'd0, rx_empty}, 16'd1);
    // R11 status write
    set_ptr(0, 1, 0, 1); set_pnum(3);
    @(negedge clk); txf_valid = 1; txf_pnum = 2'd3; txf_status = 16'hA5C3;
    acc_valid = 1; acc_byte = 0; #1;
    chk("R11 status priority", {15'd0, acc_ready}, 16'd0);
    @(negedge clk); txf_valid = 0; acc_valid = 0;
    do_rd(0, d); chk("R11 status readback", d, 16'hA5C3);
    do_rd(0, d); chk("R11 following word", d, {pat(3, 3), 8'h12});
    // R10 back-pressure
    set_pnum(1); set_ptr(30, 1, 0, 1);
    rsp_ready = 0;
    @(negedge clk); acc_valid = 1; acc_byte = 0;
    @(negedge clk); acc_valid = 0; held = rsp_data;
    chk("R10 response valid", {15'd0, rsp_valid}, 16'd1);
    chk("R10 response data", held, wpat(1, 30));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); acc_valid = 1; #1;
      chk("R10 held valid", {15'd0, rsp_valid}, 16'd1);
      chk("R10 held data", rsp_data, held);
      chk("R10 ready low", {15'd0, acc_ready}, 16'd0);
    end
    @(negedge clk); acc_valid = 0; rsp_ready = 1;
    @(negedge clk);
    chk("R10 drained", {15'd0, rsp_valid}, 16'd0);
    do_rd(0, d); chk("R10 single advance", d, wpat(1, 32));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule